// File: doc/BRIEF.md
# Data-Processing Cycle Sequencer

This block issues the bus cycle types for a single data-processing operation, one code per clock. A start strobe launches a sequence. Two qualifier flags, sampled together with the strobe, choose the mix of cycles. One flag says the shift amount is taken from a register. The other says the result goes to the program counter. Cycles are sequential (S), non-sequential (N) or internal (I). When no sequence is running, the output shows an idle code.

A shift amount taken from a register costs one internal cycle. That cycle comes before the rest of the sequence, because the amount has to be read before it can be applied. A result written to the program counter turns the operation into a refill. The refill is one N cycle that fetches from the new address, followed by two S cycles that refill the pipeline. While the refill runs, a refill indication is raised. A one-clock done pulse marks the final cycle of every sequence.

Decoding, the ALU datapath and memory timing are handled elsewhere. The block only orders the cycle types.

Top module: `dpCycleSeq`

## Requirements
- R1: While reset is held, and on the first cycle after it, the cycle code is 2'b11 (idle), and refill and done are low.
- R2: A start with both flags low gives a single cycle of code 2'b00 (S) with done high, in the clock after start is sampled, then idle.
- R3: A start with only the register-shift flag high gives code 2'b10 (I) and then 2'b00 (S). Done is high on the S cycle only.
- R4: A start with only the program-counter flag high gives 2'b01 (N), 2'b00, 2'b00. Done is high on the third cycle only.
- R5: A start with both flags high gives 2'b10, 2'b01, 2'b00, 2'b00. Done is high on the fourth cycle only.
- R6: Done is never high on two consecutive cycles.
- R7: Whenever done is high, the cycle code is 2'b00 (S).
- R8: Refill is high on every N cycle and on the two S cycles that follow it. Refill is low on I cycles, on idle cycles and on every other S cycle. An N cycle is always followed by an S cycle with refill high.
- R9: A start, or a change of either flag, is ignored while a sequence is running, including on the done cycle. The cycle after done is always idle. A start seen while idle always begins a sequence on the next cycle.
- R10: An I cycle is always followed by an S or an N cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches a sequence when the block is idle |
| regShift | input | 1 | Shift amount comes from a register; sampled with start |
| pcWrite | input | 1 | Result goes to the program counter; sampled with start |
| cycType | output | 2 | Cycle code: 00 S, 01 N, 10 I, 11 idle |
| refill | output | 1 | High during the N cycle and the two refill S cycles |
| done | output | 1 | One-clock pulse on the last cycle of a sequence |

## Verification
The checker watches the local cycle-to-cycle rules on every clock:
- done lasts one cycle and falls on an S cycle;
- refill tracks the N cycle and the S cycles after it;
- an I cycle is never followed by idle;
- an idle start is always taken, and a done cycle is always followed by idle.

Those rules cannot tell which whole sequence belongs to which pair of flags. The bench scenarios establish that: the exact ordered code sequences for the four flag combinations, the reset state, and the fact that a held start and flags changing mid-sequence leave a running sequence untouched.

// File: rtl/dpSeqPkg.sv
package dpSeqPkg;
  localparam int CYC_W = 2;

  typedef enum logic [CYC_W-1:0] {
    CYC_S    = 2'b00,
    CYC_N    = 2'b01,
    CYC_I    = 2'b10,
    CYC_IDLE = 2'b11
  } cycKind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_EXEC,
    ST_FETCH,
    ST_FILL1,
    ST_FILL2
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic issueS;
    logic issueN;
    logic issueI;
    logic refill;
    logic last;
  } seqStrobe_t;
endpackage

// File: rtl/dpSeqCtrl.sv
module dpSeqCtrl
  import dpSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       regShift,
  input  logic       pcWrite,
  input  logic       pcHeld,
  output seqStrobe_t strobe
);
  seqState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE: if (start) begin
        if (regShift)     stateD = ST_SHIFT;
        else if (pcWrite) stateD = ST_FETCH;
        else              stateD = ST_EXEC;
      end
      ST_SHIFT: stateD = pcHeld ? ST_FETCH : ST_EXEC;
      ST_FETCH: stateD = ST_FILL1;
      ST_FILL1: stateD = ST_FILL2;
      ST_FILL2: stateD = ST_IDLE;
      ST_EXEC:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    strobe        = '0;
    strobe.accept = (stateQ == ST_IDLE) && start;
    strobe.issueI = (stateQ == ST_SHIFT);
    strobe.issueN = (stateQ == ST_FETCH);
    strobe.issueS = (stateQ == ST_EXEC) || (stateQ == ST_FILL1) || (stateQ == ST_FILL2);
    strobe.refill = (stateQ == ST_FETCH) || (stateQ == ST_FILL1) || (stateQ == ST_FILL2);
    strobe.last   = (stateQ == ST_EXEC) || (stateQ == ST_FILL2);
  end
endmodule

// File: rtl/dpSeqPath.sv
module dpSeqPath
  import dpSeqPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic             pcWrite,
  output logic             pcHeld,
  output logic [CYC_W-1:0] cycType,
  output logic             refill,
  output logic             done
);
  // program-counter flag kept for use after an internal cycle
  always_ff @(posedge clk) begin
    if (!rstN)              pcHeld <= 1'b0;
    else if (strobe.accept) pcHeld <= pcWrite;
  end

  cycKind_e kind;
  always_comb begin
    if (strobe.issueI)      kind = CYC_I;
    else if (strobe.issueN) kind = CYC_N;
    else if (strobe.issueS) kind = CYC_S;
    else                    kind = CYC_IDLE;
  end

  assign cycType = kind;
  assign refill  = strobe.refill;
  assign done    = strobe.last;
endmodule

// File: rtl/dpCycleSeq.sv
module dpCycleSeq
  import dpSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       regShift,
  input  logic       pcWrite,
  output logic [1:0] cycType,
  output logic       refill,
  output logic       done
);
  seqStrobe_t strobe;
  logic       pcHeld;

  dpSeqCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .regShift(regShift),
    .pcWrite(pcWrite), .pcHeld(pcHeld), .strobe(strobe)
  );

  dpSeqPath path_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pcWrite(pcWrite),
    .pcHeld(pcHeld), .cycType(cycType), .refill(refill), .done(done)
  );
endmodule

// File: rtl/dpCycleSeq_chk.sv
module dpCycleSeq_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic [1:0] cycType,
  input logic       refill,
  input logic       done
);
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_on_s_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cycType == 2'b00);

  assert_refill_on_n_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycType == 2'b01 |-> refill);

  assert_n_then_fill_R8: assert property (@(posedge clk) disable iff (!rstN)
    cycType == 2'b01 |=> (cycType == 2'b00 && refill));

  assert_refill_kind_R8: assert property (@(posedge clk) disable iff (!rstN)
    refill |-> (cycType == 2'b01 || cycType == 2'b00));

  assert_idle_after_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> cycType == 2'b11);

  assert_idle_start_taken_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cycType == 2'b11 && start) |=> cycType != 2'b11);

  assert_i_then_work_R10: assert property (@(posedge clk) disable iff (!rstN)
    cycType == 2'b10 |=> (cycType == 2'b00 || cycType == 2'b01));
endmodule

bind dpCycleSeq dpCycleSeq_chk chk_i (
  .clk(clk), .rstN(rstN), .start(start), .cycType(cycType),
  .refill(refill), .done(done)
);

// File: tb/dpCycleSeq_tb_top.sv
`timescale 1ns/1ps
module dpCycleSeq_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       regShift = 1'b0;
  logic       pcWrite = 1'b0;
  logic [1:0] cycType;
  logic       refill;
  logic       done;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dpCycleSeq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .regShift(regShift),
    .pcWrite(pcWrite), .cycType(cycType), .refill(refill), .done(done)
  );

  // {regShift, pcWrite, length, codes (first in [1:0]), refill mask (first in bit 0)}
  typedef struct packed {
    logic       rs;
    logic       pc;
    logic [2:0] len;
    logic [7:0] codes;
    logic [3:0] rmask;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{1'b0, 1'b0, 3'd1, 8'b00_00_00_00, 4'b0000},
    '{1'b1, 1'b0, 3'd2, 8'b00_00_00_10, 4'b0000},
    '{1'b0, 1'b1, 3'd3, 8'b00_00_00_01, 4'b0111},
    '{1'b1, 1'b1, 3'd4, 8'b00_00_01_10, 4'b1110}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic checkIdle(input string tag);
    check({tag, " cycType"}, cycType, 3);
    check({tag, " refill"}, refill, 0);
    check({tag, " done"}, done, 0);
  endtask

  // start sampled at the next posedge; outputs sampled at negedges
  task automatic runVec(input vec_t v, input bit holdStart, input string tag);
    @(negedge clk);
    start = 1'b1; regShift = v.rs; pcWrite = v.pc;
    for (int i = 0; i < int'(v.len); i++) begin
      @(negedge clk);
      check({tag, " code"}, cycType, int'(v.codes[2*i +: 2]));
      check({tag, " refill"}, refill, int'(v.rmask[i]));
      check({tag, " done"}, done, (i == int'(v.len) - 1) ? 1 : 0);
      if (!holdStart) start = 1'b0;
      else begin regShift = ~regShift; pcWrite = ~pcWrite; end
    end
    @(negedge clk);
    checkIdle({tag, " idle after done R9"});
    start = 1'b0; regShift = 1'b0; pcWrite = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkIdle("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 after reset");

    for (int k = 0; k < 4; k++) begin
      string tag;
      case (k)
        0: tag = "R2 plain";
        1: tag = "R3 regshift";
        2: tag = "R4 pcwrite";
        default: tag = "R5 both";
      endcase
      runVec(VECS[k], 1'b0, tag);
    end

    // R9: held start and toggling flags ignored mid-sequence; R6 R7 R8 R10 covered too
    runVec(VECS[2], 1'b1, "R9 held start pc");
    runVec(VECS[3], 1'b1, "R9 held start both");
    runVec(VECS[1], 1'b1, "R9 held start rs");

    // idle start accepted after a dwell
    repeat (4) @(negedge clk);
    checkIdle("R1 idle dwell");
    runVec(VECS[0], 1'b0, "R2 after dwell");

    // reset mid-sequence returns to idle
    @(negedge clk);
    start = 1'b1; regShift = 1'b1; pcWrite = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkIdle("R1 reset mid-run");
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 release mid-run");
    runVec(VECS[3], 1'b0, "R5 after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule